// File: doc/BRIEF.md
# SD Command Issue Engine

This block sends one SD command at a time on the single-bit command line and collects the card's answer. A command request carries a 6-bit index, a 32-bit argument, a 2-bit response kind and a one-bit request tag. The engine accepts it with a valid/ready handshake, packs the 48-bit frame and computes its CRC7. It then shifts the frame out most significant bit first, advancing one bit on each card-clock enable pulse. The packed frame is also kept in three 16-bit staging words that other logic can read.

When a response is expected, the engine releases the line and waits two card-clock enables. It then hunts for a start bit, allowing at most sixteen times the programmed timeout value in enables. It shifts in a short (48-bit) or long (136-bit) response and lays it out in eight 16-bit response words. Short responses get a CRC7 check. When a command ends, the status pins update and the request tag is copied to `st_tag`. Software treats status as current only once `st_tag` equals the tag it sent. The request port follows normal back-pressure rules: `cmd_ready` is high only while the engine is idle. An offer made while busy is not taken and raises a sticky busy flag, so the requester should withdraw it and retry later.

Top module: `sd_cmd_engine`

## Requirements
- R1: The transmitted frame is, from first to last bit: byte 0x40 OR the 6-bit index, the argument most significant byte first, then CRC7 (x^7+x^3+1, zero start, over the first 40 bits) shifted left by one with a 1 in bit 0. The first bit appears on `cmd_line_o` in the cycle after acceptance, and each bit is held until a `card_ce` pulse consumes it. `cmd_line_oe` is high for exactly those 48 bits.
- R2: After acceptance, `stage_w3` = {byte0, byte1}, `stage_w2` = {byte2, byte3} and `stage_w1` = {byte4, byte5}, with the earlier byte in bits 15:8.
- R3: `cmd_ready` is low while not idle. A `cmd_valid` seen then is not taken and leaves the staging words and the running command unchanged. It sets `st_busy` from the next cycle until the next accepted command.
- R4: `st_idle` drops in the cycle after acceptance. `st_tag` keeps the previous command's tag until the command ends, and at the end it takes the accepted `cmd_tag`.
- R5: Response kind 2'b01 is short. The 48 received bits (start bit first) fill the response vector bits 47:0 and all other bits are zero. This puts the 32-bit payload at bits 39:8.
- R6: Response kind 2'b10 or 2'b11 is long. Of the 136 received bits, bits 127:8 (counted from the last bit received, which is bit 0) land in response bits 127:8, and response bits 7:0 are zero.
- R7: Kind 2'b00, or index 7 with a zero argument, expects no response. The command ends right after the end bit with `st_resp_ok`=1, `st_timeout`=0 and all response words zero.
- R8: After the end bit, two enables are ignored. The first 0 sampled within the next 16×`tmo_limit`+1 enables is the start bit. If none arrives, `st_timeout`=1, `st_resp_ok`=0 and the response words stay zero.
- R9: For a short response, `st_crc_err` is 1 exactly when the received CRC7 field (bits 7:1) differs from the CRC7 of received bits 47:8.
- R10: `cmd_line_oe` is low whenever the engine is idle or waiting for or receiving a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_ce | input | 1 | One-cycle pulse per card clock; paces all line activity |
| cmd_valid | input | 1 | Command request offered |
| cmd_ready | output | 1 | Engine idle; request is taken when both are high |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_resp_kind | input | 2 | 00 none, 01 short, 1x long |
| cmd_tag | input | 1 | Request tag echoed on completion |
| tmo_limit | input | TMO_W | Response wait limit in units of 16 enables |
| cmd_line_o | output | 1 | Command line output value |
| cmd_line_oe | output | 1 | Command line output enable |
| cmd_line_i | input | 1 | Command line input value |
| stage_w1 | output | 16 | Frame bytes 4 and 5 |
| stage_w2 | output | 16 | Frame bytes 2 and 3 |
| stage_w3 | output | 16 | Frame bytes 0 and 1 |
| resp_words | output | RESP_WORDS*16 | Response words, word i at bits 16i+15:16i |
| st_idle | output | 1 | No command in progress |
| st_resp_ok | output | 1 | Last command completed (response captured or none needed) |
| st_timeout | output | 1 | Last command saw no response start bit |
| st_crc_err | output | 1 | Last short response had a CRC7 mismatch |
| st_busy | output | 1 | A request was offered while not idle |
| st_tag | output | 1 | Tag of the last completed command |

## Verification
The checks assume that `card_ce` is a single-cycle pulse and that a request offered while busy lasts only briefly. They also assume the card drives `cmd_line_i` only while `cmd_line_oe` is low. The stimulus respects these: it makes enables every fourth clock and holds the line high outside a reply. It starts each reply at least two enables after the end bit. A busy-time offer lasts exactly one cycle, placed between two enables. The tag flips on every request, so an `st_tag` match marks the new completion and not a stale one.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int FRAME_W = 48;
  localparam int CRC_SPAN = 40;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SEND, ENG_RESP} eng_state_t;
  typedef enum logic [2:0] {RX_OFF, RX_GAP, RX_HUNT, RX_RECV, RX_FIN, RX_TOUT} rx_state_t;

  // CRC7, polynomial x^7 + x^3 + 1, register starts at zero, MSB first
  function automatic logic [6:0] crc7_calc(input logic [CRC_SPAN-1:0] bits);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = CRC_SPAN - 1; i >= 0; i--) begin
      fb = bits[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction
endpackage

// File: rtl/sd_cmd_frame.sv
module sd_cmd_frame
  import sd_cmd_pkg::*;
(
  input  logic [5:0]  idx_i,
  input  logic [31:0] arg_i,
  output logic [15:0] w1_o,
  output logic [15:0] w2_o,
  output logic [15:0] w3_o
);
  logic [7:0] lead_byte;
  logic [7:0] tail_byte;
  logic [6:0] crc;

  always_comb begin
    lead_byte = 8'h40 | {2'b00, idx_i};
    crc       = crc7_calc({lead_byte, arg_i});
    tail_byte = {crc, 1'b1};
    w3_o      = {lead_byte, arg_i[31:24]};
    w2_o      = arg_i[23:8];
    w1_o      = {arg_i[7:0], tail_byte};
  end
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               line_o,
  output logic               oe_o,
  output logic               done_o
);
  localparam int CW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;
  logic               act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      act <= 1'b0;
    end else if (load_i) begin
      sh  <= frame_i;
      cnt <= CW'(FRAME_W - 1);
      act <= 1'b1;
    end else if (act && ce_i) begin
      sh <= {sh[FRAME_W-2:0], 1'b0};
      if (cnt == '0) act <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign line_o = act ? sh[FRAME_W-1] : 1'b1;
  assign oe_o   = act;
  assign done_o = act && ce_i && (cnt == '0);
endmodule

// File: rtl/sd_resp_rx.sv
module sd_resp_rx
  import sd_cmd_pkg::*;
#(
  parameter int TMO_W   = 12,
  parameter int GAP     = 2,
  parameter int SHORT_W = 48,
  parameter int RW      = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             arm_i,
  input  logic             long_i,
  input  logic [TMO_W-1:0] limit_i,
  input  logic             line_i,
  output logic             done_o,
  output logic             tmo_o,
  output logic             crc_err_o,
  output logic [RW-1:0]    words_o
);
  localparam int LONG_W = RW + 8;
  localparam int LIM_W  = TMO_W + 4;
  localparam int BCW    = $clog2(LONG_W + 1);
  localparam int GCW    = $clog2(GAP + 1);

  rx_state_t         st;
  logic [GCW-1:0]    gcnt;
  logic [LIM_W-1:0]  tcnt;
  logic [BCW-1:0]    left;
  logic [LONG_W-1:0] sreg;
  logic              long_q;
  logic [LIM_W-1:0]  lim_full;

  assign lim_full = {limit_i, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_OFF;
      gcnt   <= '0;
      tcnt   <= '0;
      left   <= '0;
      sreg   <= '0;
      long_q <= 1'b0;
    end else begin
      case (st)
        RX_OFF: if (arm_i) begin
          st     <= RX_GAP;
          gcnt   <= GCW'(GAP);
          long_q <= long_i;
        end
        RX_GAP: if (ce_i) begin
          if (gcnt == GCW'(1)) begin
            st   <= RX_HUNT;
            tcnt <= '0;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        RX_HUNT: if (ce_i) begin
          if (!line_i) begin
            st   <= RX_RECV;
            sreg <= '0;
            left <= long_q ? BCW'(LONG_W - 1) : BCW'(SHORT_W - 1);
          end else if (tcnt == lim_full) begin
            st <= RX_TOUT;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_RECV: if (ce_i) begin
          sreg <= {sreg[LONG_W-2:0], line_i};
          left <= left - 1'b1;
          if (left == BCW'(1)) st <= RX_FIN;
        end
        default: st <= RX_OFF;
      endcase
    end
  end

  assign done_o = (st == RX_FIN);
  assign tmo_o  = (st == RX_TOUT);

  always_comb begin
    crc_err_o = done_o && !long_q &&
                (crc7_calc(sreg[SHORT_W-1:8]) != sreg[7:1]);
    if (long_q) words_o = {sreg[RW-1:8], 8'h00};
    else        words_o = RW'(sreg[SHORT_W-1:0]);
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int TMO_W      = 12,
  parameter int RESP_WORDS = 8,
  parameter int GAP_CE     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     card_ce,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [5:0]               cmd_index,
  input  logic [31:0]              cmd_arg,
  input  logic [1:0]               cmd_resp_kind,
  input  logic                     cmd_tag,
  input  logic [TMO_W-1:0]         tmo_limit,
  output logic                     cmd_line_o,
  output logic                     cmd_line_oe,
  input  logic                     cmd_line_i,
  output logic [15:0]              stage_w1,
  output logic [15:0]              stage_w2,
  output logic [15:0]              stage_w3,
  output logic [RESP_WORDS*16-1:0] resp_words,
  output logic                     st_idle,
  output logic                     st_resp_ok,
  output logic                     st_timeout,
  output logic                     st_crc_err,
  output logic                     st_busy,
  output logic                     st_tag
);
  localparam int RW = RESP_WORDS * 16;

  eng_state_t       state;
  logic [15:0]      f_w1, f_w2, f_w3;
  logic             accept, tx_done, need_q, long_q, tag_q;
  logic [TMO_W-1:0] tmo_q;
  logic             rx_done, rx_tmo, rx_crc_err;
  logic [RW-1:0]    rx_words;
  logic             need_resp;

  sd_cmd_frame u_frame (
    .idx_i (cmd_index),
    .arg_i (cmd_arg),
    .w1_o  (f_w1),
    .w2_o  (f_w2),
    .w3_o  (f_w3)
  );

  assign cmd_ready = (state == ENG_IDLE);
  assign st_idle   = (state == ENG_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign need_resp = (cmd_resp_kind != 2'b00) &&
                     !((cmd_index == 6'd7) && (cmd_arg == 32'd0));

  sd_cmd_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_i    (card_ce),
    .load_i  (accept),
    .frame_i ({f_w3, f_w2, f_w1}),
    .line_o  (cmd_line_o),
    .oe_o    (cmd_line_oe),
    .done_o  (tx_done)
  );

  sd_resp_rx #(.TMO_W(TMO_W), .GAP(GAP_CE), .SHORT_W(FRAME_W), .RW(RW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_i      (card_ce),
    .arm_i     (tx_done && need_q),
    .long_i    (long_q),
    .limit_i   (tmo_q),
    .line_i    (cmd_line_i),
    .done_o    (rx_done),
    .tmo_o     (rx_tmo),
    .crc_err_o (rx_crc_err),
    .words_o   (rx_words)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ENG_IDLE;
      stage_w1   <= '0;
      stage_w2   <= '0;
      stage_w3   <= '0;
      resp_words <= '0;
      st_resp_ok <= 1'b0;
      st_timeout <= 1'b0;
      st_crc_err <= 1'b0;
      st_busy    <= 1'b0;
      st_tag     <= 1'b0;
      need_q     <= 1'b0;
      long_q     <= 1'b0;
      tag_q      <= 1'b0;
      tmo_q      <= '0;
    end else begin
      if (cmd_valid && !cmd_ready) st_busy <= 1'b1;
      case (state)
        ENG_IDLE: if (accept) begin
          state      <= ENG_SEND;
          stage_w1   <= f_w1;
          stage_w2   <= f_w2;
          stage_w3   <= f_w3;
          resp_words <= '0;
          st_resp_ok <= 1'b0;
          st_timeout <= 1'b0;
          st_crc_err <= 1'b0;
          st_busy    <= 1'b0;
          need_q     <= need_resp;
          long_q     <= cmd_resp_kind[1];
          tag_q      <= cmd_tag;
          tmo_q      <= tmo_limit;
        end
        ENG_SEND: if (tx_done) begin
          if (need_q) begin
            state <= ENG_RESP;
          end else begin
            state      <= ENG_IDLE;
            st_resp_ok <= 1'b1;
            st_tag     <= tag_q;
          end
        end
        ENG_RESP: begin
          if (rx_done) begin
            state      <= ENG_IDLE;
            resp_words <= rx_words;
            st_crc_err <= rx_crc_err;
            st_resp_ok <= 1'b1;
            st_tag     <= tag_q;
          end else if (rx_tmo) begin
            state      <= ENG_IDLE;
            st_timeout <= 1'b1;
            st_tag     <= tag_q;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic card_ce,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic cmd_line_o,
  input logic cmd_line_oe,
  input logic st_idle,
  input logic st_busy,
  input logic st_resp_ok,
  input logic st_timeout
);
  // R1
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_line_oe) |-> !cmd_line_o);

  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_line_oe && !card_ce) |=> (!cmd_line_oe || $stable(cmd_line_o)));

  // R3
  not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_idle |-> !cmd_ready);

  // R3
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_idle && cmd_valid) |=> st_busy);

  // R4
  leave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !st_idle);

  // R8
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_timeout |-> !st_resp_ok);

  // R10
  line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !cmd_line_oe);
endmodule

bind sd_cmd_engine sd_cmd_engine_chk chk_i (.*);

// File: tb/sd_cmd_engine_tb_top.sv
module sd_cmd_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ce_div = '0;
  logic card_ce;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [5:0] cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0] cmd_resp_kind = '0;
  logic cmd_tag = 1'b0;
  logic [11:0] tmo_limit = 12'd2;
  logic cmd_line_o, cmd_line_oe;
  logic cmd_line_i = 1'b1;
  logic [15:0] stage_w1, stage_w2, stage_w3;
  logic [127:0] resp_words;
  logic st_idle, st_resp_ok, st_timeout, st_crc_err, st_busy, st_tag;

  int total = 0;
  int bad = 0;
  logic prev_tag = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) ce_div <= ce_div + 2'd1;
  assign card_ce = (ce_div == 2'd3);

  sd_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .card_ce(card_ce),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .cmd_resp_kind(cmd_resp_kind), .cmd_tag(cmd_tag),
    .tmo_limit(tmo_limit),
    .cmd_line_o(cmd_line_o), .cmd_line_oe(cmd_line_oe), .cmd_line_i(cmd_line_i),
    .stage_w1(stage_w1), .stage_w2(stage_w2), .stage_w3(stage_w3),
    .resp_words(resp_words),
    .st_idle(st_idle), .st_resp_ok(st_resp_ok), .st_timeout(st_timeout),
    .st_crc_err(st_crc_err), .st_busy(st_busy), .st_tag(st_tag)
  );

  task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc7(input logic [39:0] d);
    logic [6:0] r = 7'd0;
    for (int k = 39; k >= 0; k--) begin
      if (d[k] ^ r[6]) r = {r[5:0], 1'b0} ^ 7'b0001001;
      else             r = {r[5:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] head = {2'b01, idx, arg};
    return {head, ref_crc7(head), 1'b1};
  endfunction

  task automatic wait_ce_now();
    while (!card_ce) @(negedge clk);
  endtask

  task automatic wait_ce_next();
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!card_ce) @(negedge clk);
  endtask

  // mode: 0 no reply, 1 short good crc, 2 short bad crc, 3 long
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                         input logic [11:0] tmo, input int mode, input int dly, input bit poke);
    logic [47:0]  exp_f = ref_frame(idx, arg);
    logic [47:0]  got = '0;
    logic [135:0] rf = '0;
    logic [127:0] exp_w = '0;
    int           nbits = 0;
    int           oe_bad = 0;
    bit           need = (kind != 2'b00) && !(idx == 6'd7 && arg == 32'd0);
    bit           exp_tmo, exp_crc;
    logic         tag = ~prev_tag;

    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; cmd_resp_kind = kind; cmd_tag = tag; tmo_limit = tmo;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    // R2: staging words
    chk("R2 stage words", {88'd0, stage_w3, stage_w2, stage_w1}, {88'd0, exp_f});
    // R4: left idle, tag not yet updated
    chk("R4 busy after accept", {135'd0, st_idle}, 136'd0);
    chk("R4 tag held", {135'd0, st_tag}, {135'd0, prev_tag});

    for (int i = 0; i < 48; i++) begin
      if (i == 0) wait_ce_now(); else wait_ce_next();
      got[47-i] = cmd_line_o;
      if (!cmd_line_oe) oe_bad++;
      if (poke && i == 5) begin
        cmd_valid = 1'b1;
        cmd_index = ~idx;
        cmd_arg = ~arg;
      end
    end
    // R1: frame content and drive enable
    chk("R1 frame bits", {88'd0, got}, {88'd0, exp_f});
    chk("R1 oe during frame", 136'(oe_bad), 136'd0);

    if (mode != 0) begin
      if (mode == 3) begin
        nbits = 136;
        rf[135:128] = 8'h3f;
        rf[127:8] = {$urandom(), $urandom(), $urandom(), 24'($urandom())};
        rf[7:0] = {7'($urandom()), 1'b1};
        exp_w = {rf[127:8], 8'h00};
      end else begin
        nbits = 48;
        rf[47:8] = {2'b00, 6'($urandom()), $urandom()};
        rf[7:1] = ref_crc7(rf[47:8]) ^ ((mode == 2) ? 7'h10 : 7'h00);
        rf[0] = 1'b1;
        exp_w = {80'd0, rf[47:0]};
      end
      for (int i = 0; i < dly; i++) begin wait_ce_next(); cmd_line_i = 1'b1; end
      for (int i = 0; i < nbits; i++) begin wait_ce_next(); cmd_line_i = rf[nbits-1-i]; end
      wait_ce_next();
      cmd_line_i = 1'b1;
    end

    for (int c = 0; c < 4000; c++) begin
      if (st_idle && st_tag == tag) break;
      @(negedge clk);
    end

    exp_tmo = need && (mode == 0 || dly > 16 * int'(tmo) + 2);
    exp_crc = need && !exp_tmo && mode == 2;
    if (!need || exp_tmo) exp_w = '0;
    if (!need) begin
      // R7: no response expected
      chk("R7 done without reply", {133'd0, st_resp_ok, st_timeout, st_crc_err}, {133'd0, 3'b100});
    end else begin
      // R8: timeout window
      chk("R8 timeout flag", {134'd0, st_timeout, st_resp_ok}, {134'd0, exp_tmo, ~exp_tmo});
      // R9: crc check
      chk("R9 crc flag", {135'd0, st_crc_err}, {135'd0, exp_crc});
    end
    // R5 short layout, R6 long layout
    chk((mode == 3) ? "R6 long words" : "R5 short words", {8'd0, resp_words}, {8'd0, exp_w});
    chk("R4 tag echo", {134'd0, st_idle, st_tag}, {134'd0, 1'b1, tag});
    chk("R10 line released", {135'd0, cmd_line_oe}, 136'd0);
    if (poke) begin
      // R3: offer during busy flagged, frame and staging unaffected
      chk("R3 busy flag", {135'd0, st_busy}, {135'd0, 1'b1});
      chk("R3 staging kept", {88'd0, stage_w3, stage_w2, stage_w1}, {88'd0, exp_f});
    end else begin
      chk("R3 busy clear", {135'd0, st_busy}, 136'd0);
    end
    prev_tag = tag;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R4 reset idle/tag", {132'd0, st_idle, cmd_ready, st_tag, st_busy}, {132'd0, 4'b1100});
    chk("R10 reset line", {134'd0, cmd_line_oe, st_timeout}, 136'd0);

    // R1 known frame: index 0, arg 0 ends in 0x95
    run_cmd(6'd0, 32'd0, 2'b00, 12'd2, 0, 0, 1'b0);
    chk("R1 known frame", {88'd0, stage_w3, stage_w2, stage_w1}, {88'd0, 48'h400000000095});
    // R7 deselect: index 7, zero argument, short kind
    run_cmd(6'd7, 32'd0, 2'b01, 12'd2, 0, 0, 1'b0);
    // R5 select with reply
    run_cmd(6'd7, 32'h1234_0000, 2'b01, 12'd2, 1, 3, 1'b0);
    // R8 no reply
    run_cmd(6'd13, 32'h0000_0001, 2'b01, 12'd1, 0, 0, 1'b0);
    // R8 boundary: last accepted start position and one past
    run_cmd(6'd17, 32'h0000_0200, 2'b01, 12'd1, 1, 18, 1'b0);
    run_cmd(6'd17, 32'h0000_0400, 2'b01, 12'd1, 1, 19, 1'b0);
    // R8 minimum gap
    run_cmd(6'd55, 32'hffff_ffff, 2'b01, 12'd0, 1, 2, 1'b0);
    // R9 bad crc
    run_cmd(6'd8, 32'h0000_01aa, 2'b01, 12'd2, 2, 4, 1'b0);
    // R6 long reply
    run_cmd(6'd2, 32'd0, 2'b10, 12'd2, 3, 5, 1'b0);
    run_cmd(6'd9, 32'hbeef_0000, 2'b11, 12'd2, 3, 2, 1'b0);
    // R3 offer while busy
    run_cmd(6'd24, 32'h0000_8000, 2'b01, 12'd2, 1, 6, 1'b1);
    run_cmd(6'd3, 32'd0, 2'b01, 12'd2, 1, 3, 1'b0);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] k = 2'($urandom());
      int m;
      if (k == 2'b00) m = 0;
      else if (k == 2'b01) m = int'($urandom_range(0, 2));
      else m = ($urandom_range(0, 3) == 0) ? 0 : 3;
      run_cmd(6'($urandom()), $urandom(), k, 12'd2, m,
              int'($urandom_range(2, 20)), ($urandom_range(0, 4) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule